// File: doc/BRIEF.md
# Instruction Cache Valid-Bit Invalidation Sequencer

This block owns the valid bit of every entry in a 512-entry instruction-cache tag store and sequences the clearing of those bits. A full invalidation is requested by writing 1 to bit 24 of the control register or by a strobe from the debug port. The block then steps through every index, clearing one valid bit per clock. For the whole walk it raises a stall output, which holds off instruction fetches.

A single line is invalidated by a request that carries an address. Bits [12:4] of that address select the entry. The request is refused while control bit 28 is set. The core and the debug port can each raise a line request.

Hardware reset clears the control register, which drops the cache enable. The valid bits are not reset, so startup code must run a full invalidation before it enables the cache. A fill port sets a valid bit, and a lookup port reads one back combinationally. The tag comparison and the data store live outside this block.

Top module: `icache_valid_seq`

## Requirements
- R1: Writing a control word with bit 24 set, or pulsing `dbg_inv_all`, while no walk is running raises `fetch_stall` at the next clock edge. `fetch_stall` then stays high for exactly 512 cycles.
- R2: The walk clears one entry per cycle in ascending index order, starting at 0. When `fetch_stall` falls, every entry reads invalid.
- R3: Control bit 24 reads back as 1 while the walk runs and as 0 otherwise. Writing 0 to bit 24 starts nothing.
- R4: A line request clears, at the next clock edge, only the entry indexed by address bits [12:4]. The other address bits have no effect, and the other entries keep their state.
- R5: While control bit 28 reads 1, line requests from either source leave every valid bit unchanged.
- R6: The debug port can start a full invalidation (`dbg_inv_all`) and a line invalidation (`dbg_line_req`).
- R7: In a single cycle, a full request wins over any line request, and the line request is dropped. A core and a debug line request in the same cycle clear both indexed entries in that one cycle.
- R8: While a walk runs, line requests, fill requests and further full requests are absorbed. The walk still ends after 512 cycles and leaves every entry invalid.
- R9: Reset makes `ctl_rdata` read 0, `cache_en` read 0 and `fetch_stall` read 0. It does not change any valid bit.
- R10: Outside a walk, `fill_en` sets the valid bit at `fill_idx` at the next clock edge. `look_valid` shows the bit at `look_idx` without delay.
- R11: Control bits other than 24 store the written value. Bit 31 drives `cache_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the control register only |
| ctl_we | input | 1 | Core write strobe for the control register |
| ctl_wdata | input | 32 | Control write data; bit 24 starts a walk, bit 28 blocks line requests, bit 31 enables the cache |
| ctl_rdata | output | 32 | Control readback; bit 24 shows walk in progress |
| dbg_inv_all | input | 1 | Debug full-invalidate strobe |
| core_line_req | input | 1 | Core single-line invalidate strobe |
| core_line_addr | input | 32 | Address for the core line request; bits [12:4] select the entry |
| dbg_line_req | input | 1 | Debug single-line invalidate strobe |
| dbg_line_addr | input | 32 | Address for the debug line request |
| fill_en | input | 1 | Mark an entry valid |
| fill_idx | input | 9 | Entry to mark valid |
| look_idx | input | 9 | Entry to read |
| look_valid | output | 1 | Valid bit of `look_idx` |
| cache_en | output | 1 | Cache enable, taken from control bit 31 |
| fetch_stall | output | 1 | High while the full walk runs |

## Verification
Register writes, line clears and fills take effect at the first clock edge after the stimulus. The bench drives each stimulus for one cycle starting at a falling edge, releases it at the next falling edge, and samples there. Reads of `look_valid` are combinational, so the bench sets the index at a falling edge and reads it a moment later. `fetch_stall` is first seen at the falling edge that follows the start request. The bench counts the falling edges at which it is high and expects 512, even while absorbed stimuli are fed in during the walk.

// File: rtl/icv_pkg.sv
package icv_pkg;
    localparam int CTL_W         = 32;
    localparam int CTL_INV_ALL   = 24;
    localparam int CTL_LINE_INH  = 28;
    localparam int CTL_ENABLE    = 31;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } walk_st_e;
endpackage

// File: rtl/icv_req_merge.sv
module icv_req_merge
    import icv_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 9,
    parameter int IDX_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              dbg_inv_all,
    input  logic              core_line_req,
    input  logic [ADDR_W-1:0] core_line_addr,
    input  logic              dbg_line_req,
    input  logic [ADDR_W-1:0] dbg_line_addr,
    input  logic              walking,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              start_walk,
    output logic              clr0_en,
    output logic [IDX_W-1:0]  clr0_idx,
    output logic              clr1_en,
    output logic [IDX_W-1:0]  clr1_idx
);
    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } merge_st_t;

    merge_st_t st_d, st_q;
    logic full_any;
    logic line_ok;

    always_comb begin
        st_d     = st_q;
        full_any = (ctl_we && ctl_wdata[CTL_INV_ALL]) || dbg_inv_all;
        if (ctl_we) begin
            st_d.ctl               = ctl_wdata;
            st_d.ctl[CTL_INV_ALL]  = 1'b0;
        end
        start_walk = full_any && !walking;
        line_ok    = !walking && !full_any && !st_q.ctl[CTL_LINE_INH];
        clr0_en    = line_ok && core_line_req;
        clr1_en    = line_ok && dbg_line_req;
        clr0_idx   = core_line_addr[IDX_LSB +: IDX_W];
        clr1_idx   = dbg_line_addr[IDX_LSB +: IDX_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_q = st_q.ctl;

    // R5
    line_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0_en || clr1_en) |-> !ctl_q[CTL_LINE_INH]);

    // R7
    full_over_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_inv_all |-> !(clr0_en || clr1_en));
endmodule

// File: rtl/icv_walker.sv
module icv_walker
    import icv_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             active,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [IDX_W-1:0] ptr;
    } walk_t;

    walk_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        unique case (wk_q.st)
            WK_IDLE: begin
                if (start) begin
                    wk_d.st  = WK_RUN;
                    wk_d.ptr = '0;
                end
            end
            WK_RUN: begin
                if (wk_q.ptr == LAST) begin
                    wk_d.st  = WK_IDLE;
                    wk_d.ptr = '0;
                end else begin
                    wk_d.ptr = wk_q.ptr + 1'b1;
                end
            end
            default: wk_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign active  = (wk_q.st == WK_RUN);
    assign clr_en  = active;
    assign clr_idx = wk_q.ptr;

    // R2
    walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && clr_idx != LAST) |=> (active && clr_idx == $past(clr_idx) + 1'b1));

    // R1
    walk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && clr_idx == LAST) |=> !active);

    // R2
    walk_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> clr_idx == '0);
endmodule

// File: rtl/icv_valid_array.sv
module icv_valid_array #(
    parameter int DEPTH = 512,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             walk_clr_en,
    input  logic [IDX_W-1:0] walk_clr_idx,
    input  logic             clr0_en,
    input  logic [IDX_W-1:0] clr0_idx,
    input  logic             clr1_en,
    input  logic [IDX_W-1:0] clr1_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_valid
);
    logic [DEPTH-1:0] valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (fill_en)     valid_d[fill_idx]     = 1'b1;
        if (walk_clr_en) valid_d[walk_clr_idx] = 1'b0;
        if (clr0_en)     valid_d[clr0_idx]     = 1'b0;
        if (clr1_en)     valid_d[clr1_idx]     = 1'b0;
    end

    // Valid bits deliberately have no reset.
    always_ff @(posedge clk) begin
        valid_q <= valid_d;
    end

    assign look_valid = valid_q[look_idx];

    // R4
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr0_en |=> !valid_q[$past(clr0_idx)]);

    // R2
    walk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_clr_en |=> !valid_q[$past(walk_clr_idx)]);

    // R10
    fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !walk_clr_en && !clr0_en && !clr1_en) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/icache_valid_seq.sv
module icache_valid_seq
    import icv_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DEPTH   = 512,
    parameter int IDX_LSB = 4,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              dbg_inv_all,
    input  logic              core_line_req,
    input  logic [ADDR_W-1:0] core_line_addr,
    input  logic              dbg_line_req,
    input  logic [ADDR_W-1:0] dbg_line_addr,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              look_valid,
    output logic              cache_en,
    output logic              fetch_stall
);
    localparam int RUN_W = $clog2(DEPTH + 2);

    logic [CTL_W-1:0] ctl_q;
    logic             start_walk;
    logic             walking;
    logic             walk_clr_en;
    logic [IDX_W-1:0] walk_clr_idx;
    logic             clr0_en, clr1_en;
    logic [IDX_W-1:0] clr0_idx, clr1_idx;

    icv_req_merge #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .IDX_LSB(IDX_LSB)
    ) u_merge (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_we        (ctl_we),
        .ctl_wdata     (ctl_wdata),
        .dbg_inv_all   (dbg_inv_all),
        .core_line_req (core_line_req),
        .core_line_addr(core_line_addr),
        .dbg_line_req  (dbg_line_req),
        .dbg_line_addr (dbg_line_addr),
        .walking       (walking),
        .ctl_q         (ctl_q),
        .start_walk    (start_walk),
        .clr0_en       (clr0_en),
        .clr0_idx      (clr0_idx),
        .clr1_en       (clr1_en),
        .clr1_idx      (clr1_idx)
    );

    icv_walker #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_walker (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_walk),
        .active (walking),
        .clr_en (walk_clr_en),
        .clr_idx(walk_clr_idx)
    );

    icv_valid_array #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_valid (
        .clk         (clk),
        .rst_n       (rst_n),
        .walk_clr_en (walk_clr_en),
        .walk_clr_idx(walk_clr_idx),
        .clr0_en     (clr0_en),
        .clr0_idx    (clr0_idx),
        .clr1_en     (clr1_en),
        .clr1_idx    (clr1_idx),
        .fill_en     (fill_en && !walking),
        .fill_idx    (fill_idx),
        .look_idx    (look_idx),
        .look_valid  (look_valid)
    );

    always_comb begin
        ctl_rdata              = ctl_q;
        ctl_rdata[CTL_INV_ALL] = walking;
    end

    assign cache_en    = ctl_q[CTL_ENABLE];
    assign fetch_stall = walking;

    // Length of the current stall run, used by the window check below.
    logic [RUN_W-1:0] run_d, run_q;
    always_comb begin
        run_d = fetch_stall ? run_q + 1'b1 : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R1
    stall_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(DEPTH));

    // R1
    stall_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_stall) |-> run_q == RUN_W'(DEPTH));

    // R1
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_stall) |-> $past(start_walk));

    // R11
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(cache_en));
endmodule

// File: tb/test_icache_valid_seq.sv
module test_icache_valid_seq;
    localparam int DEPTH = 512;
    localparam int IW    = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        dbg_inv_all = 1'b0;
    logic        core_line_req = 1'b0;
    logic [31:0] core_line_addr = '0;
    logic        dbg_line_req = 1'b0;
    logic [31:0] dbg_line_addr = '0;
    logic        fill_en = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [IW-1:0] look_idx = '0;
    logic        look_valid;
    logic        cache_en;
    logic        fetch_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    icache_valid_seq i_icache_valid_seq (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dbg_inv_all(dbg_inv_all),
        .core_line_req(core_line_req), .core_line_addr(core_line_addr),
        .dbg_line_req(dbg_line_req), .dbg_line_addr(dbg_line_addr),
        .fill_en(fill_en), .fill_idx(fill_idx),
        .look_idx(look_idx), .look_valid(look_valid),
        .cache_en(cache_en), .fetch_stall(fetch_stall)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int idx, input logic [31:0] junk);
        return (junk & 32'hFFFF_E00F) | (32'(idx) << 4);
    endfunction

    task automatic wr_ctl(input logic [31:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic fill(input int idx);
        @(negedge clk); fill_en = 1'b1; fill_idx = IW'(idx);
        @(negedge clk); fill_en = 1'b0;
    endtask

    task automatic rd(input int idx, output bit v);
        look_idx = IW'(idx); #1; v = look_valid;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (fetch_stall && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic all_invalid(input string req);
        int bad = 0;
        bit v;
        for (int i = 0; i < DEPTH; i++) begin rd(i, v); if (v) bad++; end
        chk(bad == 0, req, "valid entries after walk", bad, 0);
    endtask

    task automatic t_reset;
        chk(ctl_rdata == 32'h0, "R9", "ctl_rdata after reset", ctl_rdata, 0);
        chk(cache_en == 1'b0, "R9", "cache_en after reset", cache_en, 0);
        chk(fetch_stall == 1'b0, "R9", "stall after reset", fetch_stall, 0);
    endtask

    task automatic t_full_core;
        int n; bit v;
        fill(0); fill(200); fill(511);
        rd(200, v); chk(v, "R10", "fill sets entry 200", v, 1);
        wr_ctl(32'h8100_0000);
        chk(fetch_stall, "R1", "stall after start", fetch_stall, 1);
        chk(ctl_rdata[24], "R3", "bit24 during walk", ctl_rdata[24], 1);
        count_stall(n);
        chk(n == DEPTH, "R1", "stall cycles", n, DEPTH);
        chk(!ctl_rdata[24], "R3", "bit24 after walk", ctl_rdata[24], 0);
        chk(ctl_rdata == 32'h8000_0000, "R11", "ctl readback", ctl_rdata, 32'h8000_0000);
        chk(cache_en, "R11", "cache_en from bit31", cache_en, 1);
        all_invalid("R2");
    endtask

    task automatic t_zero_bit24;
        wr_ctl(32'h8000_0000);
        chk(!fetch_stall, "R3", "write 0 to bit24 stalls", fetch_stall, 0);
    endtask

    task automatic t_line;
        bit v;
        fill(37); fill(38);
        @(negedge clk); core_line_req = 1'b1; core_line_addr = mk_addr(37, 32'hDEAD_BEEF);
        @(negedge clk); core_line_req = 1'b0;
        rd(37, v); chk(!v, "R4", "core line clear 37", v, 0);
        rd(38, v); chk(v, "R4", "neighbour 38 kept", v, 1);
        chk(!fetch_stall, "R4", "no stall on line", fetch_stall, 0);
    endtask

    task automatic t_inhibit;
        bit v;
        wr_ctl(32'h9000_0000);
        fill(60);
        @(negedge clk); core_line_req = 1'b1; core_line_addr = mk_addr(60, 0);
        dbg_line_req = 1'b1; dbg_line_addr = mk_addr(60, 32'hFFFF_FFFF);
        @(negedge clk); core_line_req = 1'b0; dbg_line_req = 1'b0;
        rd(60, v); chk(v, "R5", "inhibited line kept", v, 1);
        wr_ctl(32'h8000_0000);
    endtask

    task automatic t_debug;
        int n; bit v;
        fill(90);
        @(negedge clk); dbg_line_req = 1'b1; dbg_line_addr = mk_addr(90, 32'h1234_5678);
        @(negedge clk); dbg_line_req = 1'b0;
        rd(90, v); chk(!v, "R6", "debug line clear", v, 0);
        fill(300);
        @(negedge clk); dbg_inv_all = 1'b1;
        @(negedge clk); dbg_inv_all = 1'b0;
        count_stall(n);
        chk(n == DEPTH, "R6", "debug walk cycles", n, DEPTH);
        rd(300, v); chk(!v, "R6", "debug walk cleared 300", v, 0);
    endtask

    task automatic t_merge;
        int n; bit v;
        fill(10); fill(400);
        @(negedge clk); core_line_req = 1'b1; core_line_addr = mk_addr(10, 0);
        dbg_line_req = 1'b1; dbg_line_addr = mk_addr(400, 0);
        @(negedge clk); core_line_req = 1'b0; dbg_line_req = 1'b0;
        rd(10, v);  chk(!v, "R7", "dual line clear 10", v, 0);
        rd(400, v); chk(!v, "R7", "dual line clear 400", v, 0);
        @(negedge clk); dbg_inv_all = 1'b1; core_line_req = 1'b1;
        core_line_addr = mk_addr(5, 0);
        @(negedge clk); dbg_inv_all = 1'b0; core_line_req = 1'b0;
        chk(fetch_stall, "R7", "full wins over line", fetch_stall, 1);
        count_stall(n);
        chk(n == DEPTH, "R7", "walk length after merge", n, DEPTH);
    endtask

    task automatic t_absorb;
        int n = 0;
        wr_ctl(32'h8100_0000);
        while (fetch_stall && n < 2000) begin
            n++;
            if (n == 20) begin
                core_line_req = 1'b1; core_line_addr = mk_addr(3, 0);
                dbg_inv_all = 1'b1;
                fill_en = 1'b1; fill_idx = IW'(7);
            end else if (n == 400) begin
                ctl_we = 1'b1; ctl_wdata = 32'h8100_0000;
                fill_en = 1'b1; fill_idx = IW'(500);
            end else begin
                core_line_req = 1'b0; dbg_inv_all = 1'b0; fill_en = 1'b0;
                ctl_we = 1'b0; ctl_wdata = '0;
            end
            @(negedge clk);
        end
        core_line_req = 1'b0; dbg_inv_all = 1'b0; fill_en = 1'b0; ctl_we = 1'b0;
        chk(n == DEPTH, "R8", "walk length with absorbed requests", n, DEPTH);
        all_invalid("R8");
    endtask

    task automatic t_reset_keeps;
        bit v;
        fill(123);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_rdata == 32'h0, "R9", "ctl after second reset", ctl_rdata, 0);
        chk(!cache_en, "R9", "cache_en after second reset", cache_en, 0);
        rd(123, v); chk(v, "R9", "valid kept over reset", v, 1);
        rd(124, v); chk(!v, "R9", "invalid kept over reset", v, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_full_core;
        t_zero_bit24;
        t_line;
        t_inhibit;
        t_debug;
        t_merge;
        t_absorb;
        t_reset_keeps;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule